// File: doc/BRIEF.md
# SMBus Line Timing Monitor

A passive observer for a two-wire management bus. It samples the clock and data lines, which arrive already synchronised to the system clock. From these samples it works out whether a message is in progress and whether the bus may be treated as free. It also measures how long the clock is held low. A single low interval that runs too long produces a timeout pulse. The surrounding logic uses that pulse to drop its transfer state and get ready for a new START.

Two accumulators sum the clock-low samples taken while a message is open. One covers the whole message and runs from START to STOP. The other covers one byte segment: from START to the acknowledge clock, between two acknowledge clocks, or from the last acknowledge clock to STOP. Each accumulator sets a sticky violation flag when it passes its limit. The monitor also reports a clock that stays high too long inside a message, and a bus that comes alive after a very long dead period.

Every threshold is a parameter counted in system-clock cycles. The defaults are derived from a system-clock frequency parameter given in kHz. The monitor drives nothing onto the bus. Issuing STOP or abandoning a transfer is left to the logic that uses its outputs.

Top module: `smb_line_watch`

## Requirements
- R1: While reset is held, and in the cycle after it is released, all seven outputs read 0.
- R2: A START is a sample in which SDA goes from 1 to 0 while SCL stays 1. It sets `bus_busy_o` one cycle later. A STOP is a sample in which SDA goes from 0 to 1 while SCL stays 1. It clears `bus_busy_o`.
- R3: After a STOP, `bus_idle_o` rises on the (FREE_CYC+1)-th consecutive sample in which both lines are high, with the STOP sample counted as the first. It does not rise after only FREE_CYC such samples.
- R4: With no STOP seen, `bus_idle_o` rises after more than HIGH_MAX_CYC consecutive samples with both lines high. It falls on the first sample in which either line is low. It is never 1 while `bus_busy_o` is 1.
- R5: `tmo_o` is a one-cycle pulse on the (TMO_CYC+1)-th consecutive sample with SCL low. It fires once per low interval, it clears `bus_busy_o`, and it does not fire for an interval of exactly TMO_CYC samples.
- R6: Clock-low samples taken while busy are summed from START onward. When the sum passes SEXT_CYC, `slv_ext_o` is set. The flag holds through STOP and timeout, and only the next START clears it.
- R7: Clock-low samples taken while busy are also summed per segment. The segment sum restarts at START and at each acknowledge clock, which is the 9th rising SCL edge after START or after the previous acknowledge. When the segment sum passes MEXT_CYC, `mst_ext_o` is set and holds until the next START.
- R8: While busy, if SCL stays high for more than HIGH_MAX_CYC samples after START, `stall_o` pulses for one cycle and `bus_busy_o` clears.
- R9: If the lines have not both been high for more than POR_CYC samples, `por_o` pulses for one cycle on the first sample in which both are high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line |
| bus_busy_o | output | 1 | A message is open |
| bus_idle_o | output | 1 | Bus may be treated as free |
| tmo_o | output | 1 | Single-interval clock-low timeout pulse |
| stall_o | output | 1 | Clock held high too long inside a message (pulse) |
| por_o | output | 1 | Bus became active after a long dead period (pulse) |
| slv_ext_o | output | 1 | Whole-message clock-low limit passed (sticky) |
| mst_ext_o | output | 1 | Per-segment clock-low limit passed (sticky) |

## Verification
The main stimulus is a set of messages built from byte-shaped clock trains. Short low phases spread over many bytes push only the whole-message sum past its limit. Long low phases inside a single segment push only the per-segment sum past its limit, and none of those phases is long enough to trip the single-interval timeout. This separates the three clock-low checks from one another. Long high levels are tried both inside a message and outside one, which separates the stall pulse from the no-STOP idle rule. The STOP-based idle rule and the timeout are each tested at exactly the threshold and one sample past it.

// File: rtl/smb_watch_pkg.sv
package smb_watch_pkg;

  // Conditions decoded from one sample of the bus lines.
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic both_hi;
  } line_ev_t;

endpackage

// File: rtl/smb_cond_detect.sv
module smb_cond_detect
  import smb_watch_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_i,
  input  logic     sda_i,
  output line_ev_t ev
);

  logic scl_q, sda_q;

  // The previous sample resets high, so no false edge appears after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    ev.start    = scl_q & scl_i & sda_q & ~sda_i;
    ev.stop     = scl_q & scl_i & ~sda_q & sda_i;
    ev.scl_rise = ~scl_q & scl_i;
    ev.both_hi  = scl_i & sda_i;
  end

endmodule

// File: rtl/smb_run_counter.sv
module smb_run_counter #(
  parameter int LIMIT = 10,
  parameter int W     = $clog2(LIMIT + 2)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = W'(LIMIT + 1);

  // Counts up to LIMIT+1 and stays there. A clear wins over an increment.
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && cnt != TOP)
      cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/smb_line_watch.sv
module smb_line_watch
  import smb_watch_pkg::*;
#(
  parameter int SYS_KHZ      = 100_000,
  parameter int FREE_CYC     = SYS_KHZ * 47 / 10_000,
  parameter int HIGH_MAX_CYC = SYS_KHZ / 20,
  parameter int TMO_CYC      = SYS_KHZ * 25,
  parameter int SEXT_CYC     = SYS_KHZ * 25,
  parameter int MEXT_CYC     = SYS_KHZ * 10,
  parameter int POR_CYC      = SYS_KHZ * 2500,
  parameter int SEG_CLOCKS   = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic bus_busy_o,
  output logic bus_idle_o,
  output logic tmo_o,
  output logic stall_o,
  output logic por_o,
  output logic slv_ext_o,
  output logic mst_ext_o
);

  localparam int LO_W  = $clog2(TMO_CYC + 2);
  localparam int HB_W  = $clog2(HIGH_MAX_CYC + 2);
  localparam int MS_W  = $clog2(SEXT_CYC + 2);
  localparam int SG_W  = $clog2(MEXT_CYC + 2);
  localparam int DD_W  = $clog2(POR_CYC + 2);
  localparam int BIT_W = $clog2(SEG_CLOCKS + 1);

  line_ev_t ev;

  logic [LO_W-1:0]  lo_cnt;
  logic [HB_W-1:0]  both_cnt;
  logic [HB_W-1:0]  sclhi_cnt;
  logic [MS_W-1:0]  msg_cnt;
  logic [SG_W-1:0]  seg_cnt;
  logic [DD_W-1:0]  dead_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic             stop_seen;

  logic tmo_hit, stall_hit, por_hit, idle_hit, ack_rise, low_busy;

  smb_cond_detect u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
  );

  assign low_busy = bus_busy_o & ~scl_i;
  assign ack_rise = bus_busy_o & ev.scl_rise & (bit_cnt == BIT_W'(SEG_CLOCKS - 1));

  smb_run_counter #(.LIMIT(TMO_CYC), .W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .clr(scl_i), .inc(~scl_i), .cnt(lo_cnt));

  smb_run_counter #(.LIMIT(HIGH_MAX_CYC), .W(HB_W)) u_both (
    .clk(clk), .rst(rst), .clr(~ev.both_hi), .inc(ev.both_hi), .cnt(both_cnt));

  smb_run_counter #(.LIMIT(HIGH_MAX_CYC), .W(HB_W)) u_sclhi (
    .clk(clk), .rst(rst), .clr(~scl_i | ev.start), .inc(scl_i), .cnt(sclhi_cnt));

  smb_run_counter #(.LIMIT(SEXT_CYC), .W(MS_W)) u_msg (
    .clk(clk), .rst(rst), .clr(ev.start), .inc(low_busy), .cnt(msg_cnt));

  smb_run_counter #(.LIMIT(MEXT_CYC), .W(SG_W)) u_seg (
    .clk(clk), .rst(rst), .clr(ev.start | ack_rise), .inc(low_busy), .cnt(seg_cnt));

  smb_run_counter #(.LIMIT(POR_CYC), .W(DD_W)) u_dead (
    .clk(clk), .rst(rst), .clr(ev.both_hi), .inc(~ev.both_hi), .cnt(dead_cnt));

  always_comb begin
    tmo_hit   = ~scl_i & (lo_cnt == LO_W'(TMO_CYC));
    stall_hit = bus_busy_o & scl_i & ~ev.start & (sclhi_cnt == HB_W'(HIGH_MAX_CYC));
    por_hit   = ev.both_hi & (dead_cnt > DD_W'(POR_CYC));
    idle_hit  = ev.both_hi &
                ((((stop_seen | ev.stop)) & (both_cnt >= HB_W'(FREE_CYC))) |
                 (both_cnt >= HB_W'(HIGH_MAX_CYC)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_busy_o <= 1'b0;
      bus_idle_o <= 1'b0;
      tmo_o      <= 1'b0;
      stall_o    <= 1'b0;
      por_o      <= 1'b0;
      slv_ext_o  <= 1'b0;
      mst_ext_o  <= 1'b0;
      stop_seen  <= 1'b0;
      bit_cnt    <= '0;
    end else begin
      tmo_o      <= tmo_hit;
      stall_o    <= stall_hit;
      por_o      <= por_hit;
      bus_idle_o <= idle_hit;

      if (ev.start)
        bus_busy_o <= 1'b1;
      else if (ev.stop || tmo_hit || stall_hit)
        bus_busy_o <= 1'b0;

      if (ev.stop)
        stop_seen <= 1'b1;
      else if (!ev.both_hi)
        stop_seen <= 1'b0;

      if (ev.start || ack_rise)
        bit_cnt <= '0;
      else if (bus_busy_o && ev.scl_rise)
        bit_cnt <= bit_cnt + BIT_W'(1);

      if (ev.start)
        slv_ext_o <= 1'b0;
      else if (low_busy && msg_cnt >= MS_W'(SEXT_CYC))
        slv_ext_o <= 1'b1;

      if (ev.start)
        mst_ext_o <= 1'b0;
      else if (low_busy && seg_cnt >= SG_W'(MEXT_CYC))
        mst_ext_o <= 1'b1;
    end
  end

  // Checks placed beside the logic they guard.
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy_o) |-> $past(ev.start));

  assert_idle_needs_high_R3: assert property (@(posedge clk) disable iff (rst)
    bus_idle_o |-> $past(scl_i && sda_i));

  assert_busy_idle_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(bus_busy_o && bus_idle_o));

  assert_tmo_single_R5: assert property (@(posedge clk) disable iff (rst)
    tmo_o |=> !tmo_o);

  assert_tmo_after_low_R5: assert property (@(posedge clk) disable iff (rst)
    tmo_o |-> $past(!scl_i));

  assert_slv_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(slv_ext_o) |-> $past(ev.start));

  assert_mst_hold_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(mst_ext_o) |-> $past(ev.start));

  assert_stall_drops_busy_R8: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> !bus_busy_o);

  assert_por_on_high_R9: assert property (@(posedge clk) disable iff (rst)
    por_o |-> $past(scl_i && sda_i));

endmodule

// File: tb/tb_smb_line_watch.sv
module tb_smb_line_watch;

  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 19;

  typedef struct packed {
    logic       sda;
    logic [9:0] lo;
    logic [9:0] hi;
    logic [3:0] reps;
    logic       busy;
    logic       idle;
    logic       slv;
    logic       mst;
    logic [1:0] tmo;
    logic [1:0] stall;
    logic [1:0] por;
  } row_t;

  // Each row: reps times (lo samples with SCL=0, then hi samples with SCL=1),
  // SDA held fixed; expected state and pulse counts at the end of the row.
  localparam row_t TBL [NROWS] = '{
    '{1'b1, 10'd0,   10'd45, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd0,   10'd1,  4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd0,   10'd3,  4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd5,   10'd2,  4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd5,   10'd2,  4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd5,   10'd2,  4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd5,   10'd2,  4'd9, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd5,   10'd1,  4'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b1, 10'd0,   10'd12, 4'd1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd0,   10'd1,  4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd20,  10'd2,  4'd4, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd20,  10'd2,  4'd5, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd55,  10'd0,  4'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 2'd0, 2'd0},
    '{1'b0, 10'd0,   10'd3,  4'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0},
    '{1'b1, 10'd0,   10'd10, 4'd1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd0,   10'd1,  4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 10'd0,   10'd45, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0},
    '{1'b0, 10'd400, 10'd0,  4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 2'd0},
    '{1'b1, 10'd0,   10'd5,  4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic busy, idle, tmo, stall, por, slv, mst;

  int checks = 0;
  int fails  = 0;
  int tmo_n, stall_n, por_n;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  smb_line_watch #(
    .FREE_CYC(8), .HIGH_MAX_CYC(40), .TMO_CYC(50),
    .SEXT_CYC(150), .MEXT_CYC(60), .POR_CYC(300)
  ) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
    .bus_busy_o(busy), .bus_idle_o(idle), .tmo_o(tmo), .stall_o(stall),
    .por_o(por), .slv_ext_o(slv), .mst_ext_o(mst)
  );

  function automatic string tag_of(int i);
    case (i)
      0:          return "R4";
      1, 2:       return "R2";
      3:          return "R7";
      8, 14:      return "R3";
      10, 15:     return "R7";
      12, 13, 17: return "R5";
      16:         return "R8";
      18:         return "R9";
      default:    return "R6";
    endcase
  endfunction

  // Called at a falling edge: drive, let one rising edge pass, return at the next falling edge.
  task automatic cyc(input logic c, input logic d);
    scl = c;
    sda = d;
    @(posedge clk);
    @(negedge clk);
    tmo_n   += int'(tmo);
    stall_n += int'(stall);
    por_n   += int'(por);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: every output is low right after reset.
    check("R1", {busy, idle, tmo, stall, por, slv, mst}, 0);

    tmo_n = 0; stall_n = 0; por_n = 0;
    for (int r = 0; r < NROWS; r++) begin
      tmo_n = 0; stall_n = 0; por_n = 0;
      for (int k = 0; k < int'(TBL[r].reps); k++) begin
        for (int j = 0; j < int'(TBL[r].lo); j++) cyc(1'b0, TBL[r].sda);
        for (int j = 0; j < int'(TBL[r].hi); j++) cyc(1'b1, TBL[r].sda);
      end
      check(tag_of(r),
            {busy, idle, slv, mst, tmo_n[1:0], stall_n[1:0], por_n[1:0]},
            {TBL[r].busy, TBL[r].idle, TBL[r].slv, TBL[r].mst,
             TBL[r].tmo, TBL[r].stall, TBL[r].por});
    end

    // R5 boundary: exactly the limit gives no pulse, one more gives a single-cycle pulse.
    do_reset();
    tmo_n = 0;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1);
    for (int i = 0; i < 50; i++) cyc(1'b0, 1'b1);
    check("R5", tmo_n, 0);
    cyc(1'b0, 1'b1);
    check("R5", int'(tmo), 1);
    cyc(1'b0, 1'b1);
    check("R5", int'(tmo), 0);

    // R3 boundary: 8 high samples after STOP are not enough, the 9th raises idle.
    do_reset();
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b0);
    check("R2", int'(busy), 1);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1);
    check("R3", {busy, idle}, 2'b00);
    cyc(1'b1, 1'b1);
    check("R3", int'(idle), 1);
    // R4: idle falls on the first sample with a line low.
    cyc(1'b0, 1'b1);
    check("R4", int'(idle), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule